// File: doc/BRIEF.md
# Flash Program Command Sequencer

This block decodes the command write cycles seen by a NOR-style flash memory model and applies program operations to a small internal word array. It watches a simple write bus made of an address, a data word and a one-cycle write strobe. It recognises two ways to program:

- **Standard program**: two unlock writes, a program command, then the address/data write.
- **Fast (bypass) mode**: entered by command. In this mode each word needs only a command write followed by the address/data write.

An accelerate input also forces the fast mode while it is held. Programming can only clear bits. Reads of the array are combinational at the presented address.

After each program data cycle the block raises a busy flag for a fixed number of clocks. Write strobes are ignored while busy is high. A mode flag shows whether the fast mode is active.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, every array word reads all ones, `busy_o` is 0, `bypass_o` is 0, and the sequencer is in read mode.
- R2: A standard program is four writes in this order:
  - data AAh at address 555h;
  - data 55h at address 2AAh;
  - data A0h (any address);
  - the target address and data.

  After these writes, that word reads old AND new. The low 8 data bits carry commands and the low 12 address bits carry command addresses.
- R3: An unlock write with the wrong data or the wrong address returns the sequencer to read mode. A following A0h write and address/data write then leave the array unchanged.
- R4: A program never sets a bit. Attempted 0-to-1 bits still read as 0.
- R5: After the two unlock writes, a third write of data 20h enters fast mode and raises `bypass_o`.
- R6: In fast mode, each word is programmed by a data A0h write followed by the address/data write. This repeats with no unlock cycles, at any address and in any order.
- R7: In fast mode, any write other than A0h or 90h is ignored. This includes unlock writes and address/data writes with no A0h before them.
- R8: Fast mode is left by a data 90h write followed by a data 00h write, after which `bypass_o` is 0 and program attempts have no effect. If the write after 90h is not 00h, the sequencer stays in fast mode.
- R9: While `acc_i` is high, the sequencer is in fast mode and two-write programs work. If fast mode was entered this way, dropping `acc_i` returns it to read mode.
- R10: If fast mode was entered by the 20h command, dropping `acc_i` leaves it in fast mode.
- R11: `busy_o` is high for exactly BUSY_CYC clocks after each program data cycle. Writes presented while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe, one bus cycle per clock |
| addr_i | input | ADDR_W | Write or read address |
| wdata_i | input | DATA_W | Write data |
| acc_i | input | 1 | Accelerate input, forces fast mode while high |
| rdata_o | output | DATA_W | Array word at `addr_i` |
| busy_o | output | 1 | Program in progress |
| bypass_o | output | 1 | Fast mode active |

## Verification
The bench builds the block with the following values:

| Parameter | Value |
|---|---|
| ADDR_W | 12 |
| DATA_W | 8 |
| MEM_AW | 4 |
| BUSY_CYC | 3 |

The short busy window lets the bench count every busy clock exactly. It also lets the bench slip a command write into that window and show that the write is dropped. The 16-word array lets programs reach both ends of the array and jump across it out of order.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [2:0] {
    ST_READ, ST_UL1, ST_UL2, ST_PGM, ST_BYP, ST_BYP_PGM, ST_BYP_RST
  } seq_st_e;

  localparam logic [11:0] UL_ADDR1 = 12'h555;
  localparam logic [11:0] UL_ADDR2 = 12'h2AA;
  localparam logic [7:0]  UL_DATA1 = 8'hAA;
  localparam logic [7:0]  UL_DATA2 = 8'h55;
  localparam logic [7:0]  CMD_PGM  = 8'hA0;
  localparam logic [7:0]  CMD_BYP  = 8'h20;
  localparam logic [7:0]  CMD_XIT1 = 8'h90;
  localparam logic [7:0]  CMD_XIT2 = 8'h00;
endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              acc_i,
  output logic              prog_o,
  output logic              bypass_o
);
  seq_st_e st_q, st_d;
  logic    cmd_q, cmd_d, in_byp;
  logic [7:0]  cd;
  logic [11:0] ca;

  assign cd = wdata_i[7:0];
  assign ca = addr_i[11:0];
  assign in_byp = (st_q == ST_BYP) || (st_q == ST_BYP_PGM) || (st_q == ST_BYP_RST);
  assign bypass_o = in_byp;

  always_comb begin
    st_d   = st_q;
    cmd_d  = cmd_q;
    prog_o = 1'b0;
    if (acc_i && !in_byp) begin
      st_d = ST_BYP;
    end else if (!acc_i && in_byp && !cmd_q) begin
      st_d = ST_READ;
    end else if (we_i) begin
      unique case (st_q)
        ST_READ: if (ca == UL_ADDR1 && cd == UL_DATA1) st_d = ST_UL1;
        ST_UL1:  st_d = (ca == UL_ADDR2 && cd == UL_DATA2) ? ST_UL2 : ST_READ;
        ST_UL2: begin
          if (cd == CMD_PGM) st_d = ST_PGM;
          else if (cd == CMD_BYP) begin
            st_d  = ST_BYP;
            cmd_d = 1'b1;
          end else st_d = ST_READ;
        end
        ST_PGM: begin
          prog_o = 1'b1;
          st_d   = ST_READ;
        end
        ST_BYP: begin
          if (cd == CMD_PGM) st_d = ST_BYP_PGM;
          else if (cd == CMD_XIT1) st_d = ST_BYP_RST;
        end
        ST_BYP_PGM: begin
          prog_o = 1'b1;
          st_d   = ST_BYP;
        end
        ST_BYP_RST: begin
          if (cd == CMD_XIT2) begin
            st_d  = ST_READ;
            cmd_d = 1'b0;
          end else st_d = ST_BYP;
        end
        default: st_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_READ;
      cmd_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cmd_q <= cmd_d;
    end
  end

  p_byp_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BYP_RST && we_i && cd == CMD_XIT2 && !acc_i) |=> (st_q == ST_READ));
  p_acc_forces_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acc_i) |=> bypass_o);
  p_cmd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q && in_byp && $fell(acc_i) && !we_i) |=> bypass_o);
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int BUSY_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYC);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  p_busy_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == LOAD));
  p_busy_dec_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/flash_word_array.sv
module flash_word_array #(
  parameter int DATA_W = 8,
  parameter int MEM_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              busy_i,
  input  logic [MEM_AW-1:0] idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << MEM_AW;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (prog_i) begin
      mem_q[idx_i] <= mem_q[idx_i] & wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];

  p_no_prog_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |-> !busy_i);
  p_clear_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> ((mem_q[$past(idx_i)] | $past(rdata_o)) == $past(rdata_o)));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter int MEM_AW   = 4,
  parameter int BUSY_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              acc_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              bypass_o
);
  logic we_ok, prog;

  assign we_ok = we_i & ~busy_o;

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni, .we_i(we_ok), .addr_i, .wdata_i, .acc_i,
    .prog_o(prog), .bypass_o
  );

  flash_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk_i, .rst_ni, .start_i(prog), .busy_o
  );

  flash_word_array #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_arr (
    .clk_i, .rst_ni, .prog_i(prog), .busy_i(busy_o),
    .idx_i(addr_i[MEM_AW-1:0]), .wdata_i, .rdata_o
  );
endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 12, DW = 8, MAW = 4, BC = 3;

  logic clk = 0, rst_n = 0, we = 0, acc = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic busy, byp;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .MEM_AW(MAW), .BUSY_CYC(BC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .acc_i(acc), .rdata_o(rdata), .busy_o(busy), .bypass_o(byp)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    we = 1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    we = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    addr = AW'(a);
    #1 v = rdata;
  endtask

  task automatic unlock();
    wr('h555, 'hAA);
    wr('h2AA, 'h55);
  endtask

  task automatic t_reset();
    int v;
    rd(0, v);  chk("R1 word0", v, 'hFF);
    rd(15, v); chk("R1 word15", v, 'hFF);
    chk("R1 busy", busy, 0);
    chk("R1 bypass", byp, 0);
  endtask

  task automatic t_std_prog();
    int v;
    unlock(); wr('h555, 'hA0); wr(3, 'h5A);
    chk("R2 busy after data", busy, 1);
    wait_idle();
    rd(3, v); chk("R2 programmed", v, 'h5A);
  endtask

  task automatic t_and();
    int v;
    unlock(); wr('h555, 'hA0); wr(3, 'h0F);
    wait_idle();
    rd(3, v); chk("R4 and result", v, 'h0A);
  endtask

  task automatic t_busy_len();
    int n = 0;
    unlock(); wr('h555, 'hA0); wr(5, 'h3C);
    while (busy) begin n++; @(negedge clk); end
    chk("R11 busy length", n, BC);
  endtask

  task automatic t_bad_unlock();
    int v;
    wr('h555, 'hAA); wr('h2AA, 'h56); wr('h555, 'hA0); wr(6, 'h00);
    wait_idle();
    rd(6, v); chk("R3 bad data", v, 'hFF);
    wr('h555, 'hAA); wr('h2AB, 'h55); wr('h555, 'hA0); wr(6, 'h00);
    wait_idle();
    rd(6, v); chk("R3 bad addr", v, 'hFF);
  endtask

  task automatic t_byp_cmd();
    int v;
    unlock(); wr('h555, 'h20);
    chk("R5 bypass on", byp, 1);
    wr(0, 'hA0); wr(15, 'h11); wait_idle();
    wr(0, 'hA0); wr(0, 'h22);  wait_idle();
    wr(0, 'hA0); wr(8, 'h44);  wait_idle();
    rd(15, v); chk("R6 word15", v, 'h11);
    rd(0, v);  chk("R6 word0", v, 'h22);
    rd(8, v);  chk("R6 word8", v, 'h44);
  endtask

  task automatic t_byp_ignore();
    int v;
    unlock(); wr('h555, 'h20); wr(9, 'h00);
    rd(9, v); chk("R7 no A0", v, 'hFF);
    chk("R7 still bypass", byp, 1);
    wr(0, 'hA0); wr(9, 'hF0);
    wr(0, 'hA0);           // lands while busy
    wait_idle();
    wr(9, 'h00);
    rd(9, v); chk("R11 write in busy dropped", v, 'hF0);
  endtask

  task automatic t_byp_exit();
    int v;
    wr(0, 'h90); wr(0, 'h55);
    chk("R8 stay on bad second", byp, 1);
    wr(0, 'h90); wr(0, 'h00);
    chk("R8 bypass off", byp, 0);
    wr(0, 'hA0); wr(10, 'h00); wait_idle();
    rd(10, v); chk("R8 no program after exit", v, 'hFF);
  endtask

  task automatic t_acc();
    int v;
    @(negedge clk); acc = 1;
    @(negedge clk);
    chk("R9 acc bypass", byp, 1);
    wr(0, 'hA0); wr(11, 'h0F); wait_idle();
    rd(11, v); chk("R9 acc program", v, 'h0F);
    acc = 0;
    @(negedge clk);
    chk("R9 acc release", byp, 0);
    wr(0, 'hA0); wr(11, 'h00); wait_idle();
    rd(11, v); chk("R9 read mode after release", v, 'h0F);
  endtask

  task automatic t_acc_cmd();
    int v;
    unlock(); wr('h555, 'h20);
    @(negedge clk); acc = 1;
    @(negedge clk); acc = 0;
    @(negedge clk);
    chk("R10 bypass kept", byp, 1);
    wr(0, 'hA0); wr(12, 'h77); wait_idle();
    rd(12, v); chk("R10 program", v, 'h77);
    wr(0, 'h90); wr(0, 'h00);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_std_prog();
    t_and();
    t_busy_len();
    t_bad_unlock();
    t_byp_cmd();
    t_byp_ignore();
    t_byp_exit();
    t_acc();
    t_acc_cmd();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule